// File: doc/BRIEF.md
# H-bridge gate sequencer with dead time

This block turns an enable line, a direction bit, a PWM bit and a set of fault flags into commands for the four gate drivers of a two-leg H-bridge. Each leg has a high-side and a low-side transistor. Each command takes one of three values: released (resistive standby), sink (held off) or source (driven on). The direction and PWM bits select forward drive, reverse drive or braking. In braking, both high sides conduct.

Every transistor has its own turn-on timer. A transistor that loses its request turns off at once. A transistor that gains a request stays off for a programmable number of clock cycles, so that the other device in its leg has time to stop conducting. A transistor whose request carries on across an input change is not interrupted.

Short-circuit trips are handled per transistor. A tripped device is latched off until the direction or PWM input changes. A tri-state diagnostic pin reports standby, fault and normal operation.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While `en` is low, all four gate outputs are 2'b00 (released) and `diag_oe` is 0. The value of `diag_lvl` is then of no meaning.
- R2: With `en` high and any of `flt_temp`, `flt_ovolt` or `flt_uvolt` high, all four gates are 2'b01 (sink), `diag_oe` is 1 and `diag_lvl` is 0. This takes effect in the same cycle as the flag.
- R3: With direction 0 and PWM 0, `gate_ls_a` and `gate_hs_b` source (2'b10), and `gate_hs_a` and `gate_ls_b` sink.
- R4: With direction 1 and PWM 0, `gate_hs_a` and `gate_ls_b` source, and the other two sink.
- R5: With PWM 1, whatever the direction, both high-side gates source and both low-side gates sink (braking).
- R6: `dir_in` and `pwm_in` each pass through a two-flop synchroniser. A gate whose request ends shows sink after the second rising edge that follows the input change.
- R7: A gate whose request begins stays in sink for `dead_cycles` rising edges and then sources. With `dead_cycles` = 0 it sources at once. Reset, standby and faults also count as a period without a request.
- R8: A gate whose request carries on across a direction or PWM change keeps sourcing without a gap.
- R9: A high `sc_trip[i]` while gate i sources forces gate i to sink from the next edge and pulls `diag_lvl` low. The bit index order is 0 = `gate_hs_a`, 1 = `gate_ls_a`, 2 = `gate_hs_b`, 3 = `gate_ls_b`. The other gates are unaffected. A trip on a gate that is not sourcing has no effect.
- R10: The trip latch holds until a synchronised change on direction or PWM, or until standby. The released gate then waits the dead time again before it sources.
- R11: With `en` high, no fault flag and no latched trip, `diag_oe` is 1 and `diag_lvl` is 1.
- R12: The high-side and low-side gates of one leg never source together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enable; low selects standby |
| dir_in | input | 1 | Direction select (asynchronous) |
| pwm_in | input | 1 | PWM input (asynchronous); high selects braking |
| flt_temp | input | 1 | Over-temperature flag |
| flt_ovolt | input | 1 | Supply over-voltage flag |
| flt_uvolt | input | 1 | Supply under-voltage flag |
| sc_trip | input | 4 | Per-transistor short-circuit trip, qualified externally |
| dead_cycles | input | CNT_W | Turn-on delay in clock cycles |
| gate_hs_a | output | 2 | Leg A high-side command (00 released, 01 sink, 10 source) |
| gate_ls_a | output | 2 | Leg A low-side command |
| gate_hs_b | output | 2 | Leg B high-side command |
| gate_ls_b | output | 2 | Leg B low-side command |
| diag_oe | output | 1 | Diagnostic driver enable (0 = tri-state) |
| diag_lvl | output | 1 | Diagnostic level when driven (0 = error) |

## Verification
A stuck or mis-loaded turn-on counter shows on the ports as a gate that sources too early or too late against the expected edge count. The bench therefore samples every cycle around each transition, not only at the end. A trip latch that is never set, or never cleared, shows at the next edge as a gate or `diag_lvl` value that is wrong. It is probed both across a no-change window and across a direction toggle. A wrong synchroniser depth moves every transition by one cycle and is caught by the first sample after each input change.

// File: rtl/hbg_pkg.sv
// Shared types and constants for the H-bridge gate sequencer.
// Assumes gate index order: 0 high A, 1 low A, 2 high B, 3 low B.
package hbg_pkg;
    typedef enum logic [1:0] {
        GATE_RES  = 2'b00,
        GATE_SINK = 2'b01,
        GATE_SRC  = 2'b10
    } gate_e;

    localparam int NUM_GATES = 4;
    localparam int IDX_HS_A  = 0;
    localparam int IDX_LS_A  = 1;
    localparam int IDX_HS_B  = 2;
    localparam int IDX_LS_B  = 3;
endpackage

// File: rtl/hbg_input_sync.sv
// Multi-stage synchroniser with change detect for asynchronous control bits.
// Assumes STAGES >= 2; outputs reset to zero; chg pulses one cycle per change.
module hbg_input_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             chg
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the input through one synchroniser flop.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= din;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    // Keep the last synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else prev_q <= stage_q[STAGES-1];
    end

    assign dout = stage_q[STAGES-1];
    assign chg  = |(stage_q[STAGES-1] ^ prev_q);
endmodule

// File: rtl/hbg_decode.sv
// Truth-table decode of direction and PWM into per-gate on-requests.
// Assumes synchronised inputs; pure combinational.
module hbg_decode
    import hbg_pkg::*;
(
    input  logic                 dir,
    input  logic                 pwm,
    output logic [NUM_GATES-1:0] req
);
    // Select which transistors are asked to conduct.
    always_comb begin
        req = '0;
        if (pwm) begin
            req[IDX_HS_A] = 1'b1;
            req[IDX_HS_B] = 1'b1;
        end else if (dir) begin
            req[IDX_HS_A] = 1'b1;
            req[IDX_LS_B] = 1'b1;
        end else begin
            req[IDX_LS_A] = 1'b1;
            req[IDX_HS_B] = 1'b1;
        end
    end
endmodule

// File: rtl/hbg_gate_timer.sv
// Per-gate turn-on delay: holds a gate off for `dead` cycles after its request rises.
// Assumes `req` already folds in enable, faults and trip state; reset reloads the delay.
module hbg_gate_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] dead,
    output logic             on
);
    logic [CNT_W-1:0] cnt_q;

    // Reload while idle, count down while requested.
    always_ff @(posedge clk) begin
        if (!rst_n || !req) cnt_q <= dead;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign on = req && (cnt_q == '0);
endmodule

// File: rtl/hbridge_gate_seq.sv
// H-bridge gate sequencer: decode, fault priority, per-gate dead time, trip latch, diagnostic.
// Assumes fault and enable inputs are already clean; dir/pwm are asynchronous.
module hbridge_gate_seq
    import hbg_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dir_in,
    input  logic             pwm_in,
    input  logic             flt_temp,
    input  logic             flt_ovolt,
    input  logic             flt_uvolt,
    input  logic [3:0]       sc_trip,
    input  logic [CNT_W-1:0] dead_cycles,
    output logic [1:0]       gate_hs_a,
    output logic [1:0]       gate_ls_a,
    output logic [1:0]       gate_hs_b,
    output logic [1:0]       gate_ls_b,
    output logic             diag_oe,
    output logic             diag_lvl
);
    logic [1:0]           ctl_sync;
    logic                 ctl_chg;
    logic [NUM_GATES-1:0] dec_req;
    logic [NUM_GATES-1:0] eff_req;
    logic [NUM_GATES-1:0] gate_on;
    logic [NUM_GATES-1:0] sc_off_q;
    logic                 flt_any;
    logic                 active;
    gate_e                gate_cmd [NUM_GATES];

    hbg_input_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({dir_in, pwm_in}),
        .dout (ctl_sync),
        .chg  (ctl_chg)
    );

    hbg_decode u_decode (
        .dir(ctl_sync[1]),
        .pwm(ctl_sync[0]),
        .req(dec_req)
    );

    assign flt_any = flt_temp | flt_ovolt | flt_uvolt;
    assign active  = en & ~flt_any;
    assign eff_req = dec_req & ~sc_off_q & {NUM_GATES{active}};

    genvar g;
    generate
        for (g = 0; g < NUM_GATES; g++) begin : g_gate
            hbg_gate_timer #(.CNT_W(CNT_W)) u_timer (
                .clk  (clk),
                .rst_n(rst_n),
                .req  (eff_req[g]),
                .dead (dead_cycles),
                .on   (gate_on[g])
            );

            // Latch a trip on a sourcing gate; a new input state or standby releases it.
            always_ff @(posedge clk) begin
                if (!rst_n || !en) sc_off_q[g] <= 1'b0;
                else if (sc_trip[g] && gate_on[g]) sc_off_q[g] <= 1'b1;
                else if (ctl_chg) sc_off_q[g] <= 1'b0;
            end

            // Apply priority: standby, then global fault, then timed request.
            always_comb begin
                if (!en) gate_cmd[g] = GATE_RES;
                else if (flt_any) gate_cmd[g] = GATE_SINK;
                else if (gate_on[g]) gate_cmd[g] = GATE_SRC;
                else gate_cmd[g] = GATE_SINK;
            end
        end
    endgenerate

    assign gate_hs_a = gate_cmd[IDX_HS_A];
    assign gate_ls_a = gate_cmd[IDX_LS_A];
    assign gate_hs_b = gate_cmd[IDX_HS_B];
    assign gate_ls_b = gate_cmd[IDX_LS_B];
    assign diag_oe   = en;
    assign diag_lvl  = ~(flt_any | (|sc_off_q));
endmodule

// File: rtl/hbg_checker.sv
// Property checker for the H-bridge gate sequencer; watches ports only.
// Assumes synchronous active-low reset and the 2-bit gate encoding from hbg_pkg.
module hbg_checker
    import hbg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       flt_temp,
    input logic       flt_ovolt,
    input logic       flt_uvolt,
    input logic [3:0] sc_trip,
    input logic [1:0] gate_hs_a,
    input logic [1:0] gate_ls_a,
    input logic [1:0] gate_hs_b,
    input logic [1:0] gate_ls_b,
    input logic       diag_oe,
    input logic       diag_lvl
);
    logic       flt_any;
    logic [1:0] gv [4];

    assign flt_any = flt_temp | flt_ovolt | flt_uvolt;
    assign gv[0]   = gate_hs_a;
    assign gv[1]   = gate_ls_a;
    assign gv[2]   = gate_hs_b;
    assign gv[3]   = gate_ls_b;

    p_leg_a_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hs_a == GATE_SRC && gate_ls_a == GATE_SRC));

    p_leg_b_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hs_b == GATE_SRC && gate_ls_b == GATE_SRC));

    p_standby_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (gate_hs_a == GATE_RES && gate_ls_a == GATE_RES &&
                 gate_hs_b == GATE_RES && gate_ls_b == GATE_RES && !diag_oe));

    p_fault_sink_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && flt_any) |-> (gate_hs_a == GATE_SINK && gate_ls_a == GATE_SINK &&
                             gate_hs_b == GATE_SINK && gate_ls_b == GATE_SINK &&
                             diag_oe && !diag_lvl));

    genvar i;
    generate
        for (i = 0; i < 4; i++) begin : g_trip
            p_trip_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n && sc_trip[i] && gv[i] == GATE_SRC) |-> (gv[i] != GATE_SRC));
        end
    endgenerate
endmodule

bind hbridge_gate_seq hbg_checker u_hbg_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .flt_temp (flt_temp),
    .flt_ovolt(flt_ovolt),
    .flt_uvolt(flt_uvolt),
    .sc_trip  (sc_trip),
    .gate_hs_a(gate_hs_a),
    .gate_ls_a(gate_ls_a),
    .gate_hs_b(gate_hs_b),
    .gate_ls_b(gate_ls_b),
    .diag_oe  (diag_oe),
    .diag_lvl (diag_lvl)
);

// File: tb/test_hbridge_gate_seq.sv
// Directed bench: one task per scenario, each checking its own results at negedges.
module test_hbridge_gate_seq;
    localparam logic [1:0] RS = 2'b00;
    localparam logic [1:0] SK = 2'b01;
    localparam logic [1:0] SR = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n, en, dir_in, pwm_in, flt_temp, flt_ovolt, flt_uvolt;
    logic [3:0] sc_trip;
    logic [7:0] dead_cycles;
    logic [1:0] gate_hs_a, gate_ls_a, gate_hs_b, gate_ls_b;
    logic       diag_oe, diag_lvl;
    int         n_checks = 0;
    int         n_fail   = 0;
    bit         done     = 1'b0;

    always #4 clk = ~clk;

    hbridge_gate_seq i_hbridge_gate_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .dir_in(dir_in), .pwm_in(pwm_in),
        .flt_temp(flt_temp), .flt_ovolt(flt_ovolt), .flt_uvolt(flt_uvolt),
        .sc_trip(sc_trip), .dead_cycles(dead_cycles),
        .gate_hs_a(gate_hs_a), .gate_ls_a(gate_ls_a),
        .gate_hs_b(gate_hs_b), .gate_ls_b(gate_ls_b),
        .diag_oe(diag_oe), .diag_lvl(diag_lvl)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare the full port state; diag_lvl only matters while driven.
    task automatic expect_state(input string tag, input logic [1:0] ha, la, hb, lb,
                                input logic oe, input logic lvl);
        n_checks++;
        if (gate_hs_a !== ha || gate_ls_a !== la || gate_hs_b !== hb || gate_ls_b !== lb ||
            diag_oe !== oe || (oe && diag_lvl !== lvl)) begin
            n_fail++;
            $display("FAIL %s: got %b %b %b %b oe=%b lvl=%b expected %b %b %b %b oe=%b lvl=%b",
                     tag, gate_hs_a, gate_ls_a, gate_hs_b, gate_ls_b, diag_oe, diag_lvl,
                     ha, la, hb, lb, oe, lvl);
        end
        // R12: no leg may have both devices sourcing.
        n_checks++;
        if ((gate_hs_a == SR && gate_ls_a == SR) || (gate_hs_b == SR && gate_ls_b == SR)) begin
            n_fail++;
            $display("FAIL R12 (%s): got %b %b %b %b expected no leg with both at %b",
                     tag, gate_hs_a, gate_ls_a, gate_hs_b, gate_ls_b, SR);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; en = 1'b0; dir_in = 1'b0; pwm_in = 1'b0;
        flt_temp = 1'b0; flt_ovolt = 1'b0; flt_uvolt = 1'b0;
        sc_trip = 4'b0; dead_cycles = 8'd3;
        tick(3);
        expect_state("R1 in reset", RS, RS, RS, RS, 1'b0, 1'b1);
        rst_n = 1'b1;
        tick(1);
        expect_state("R1 after reset", RS, RS, RS, RS, 1'b0, 1'b1);
    endtask

    task automatic t_forward;
        en = 1'b1;
        tick(2);
        expect_state("R7 forward wait", SK, SK, SK, SK, 1'b1, 1'b1);
        tick(1);
        expect_state("R3 forward R11", SK, SR, SR, SK, 1'b1, 1'b1);
    endtask

    task automatic t_reverse;
        dir_in = 1'b1;
        tick(1);
        expect_state("R6 sync latency", SK, SR, SR, SK, 1'b1, 1'b1);
        tick(1);
        expect_state("R6 old request off", SK, SK, SK, SK, 1'b1, 1'b1);
        tick(2);
        expect_state("R7 reverse wait", SK, SK, SK, SK, 1'b1, 1'b1);
        tick(1);
        expect_state("R4 reverse", SR, SK, SK, SR, 1'b1, 1'b1);
    endtask

    task automatic t_brake;
        pwm_in = 1'b1;
        tick(1);
        expect_state("R8 brake latency", SR, SK, SK, SR, 1'b1, 1'b1);
        tick(1);
        expect_state("R8 hs_a held", SR, SK, SK, SK, 1'b1, 1'b1);
        tick(2);
        expect_state("R7 hs_b wait", SR, SK, SK, SK, 1'b1, 1'b1);
        tick(1);
        expect_state("R5 brake", SR, SK, SR, SK, 1'b1, 1'b1);
    endtask

    task automatic t_brake_dir_toggle;
        dir_in = 1'b0;
        for (int k = 0; k < 5; k++) begin
            tick(1);
            expect_state("R5 R8 brake dir toggle", SR, SK, SR, SK, 1'b1, 1'b1);
        end
    endtask

    task automatic t_faults;
        flt_temp = 1'b1;
        tick(1);
        expect_state("R2 thermal", SK, SK, SK, SK, 1'b1, 1'b0);
        flt_temp = 1'b0;
        tick(2);
        expect_state("R7 after fault wait", SK, SK, SK, SK, 1'b1, 1'b1);
        tick(1);
        expect_state("R7 after fault on", SR, SK, SR, SK, 1'b1, 1'b1);
        flt_ovolt = 1'b1;
        tick(1);
        expect_state("R2 overvolt", SK, SK, SK, SK, 1'b1, 1'b0);
        flt_ovolt = 1'b0; flt_uvolt = 1'b1;
        tick(1);
        expect_state("R2 undervolt", SK, SK, SK, SK, 1'b1, 1'b0);
        flt_uvolt = 1'b0;
        tick(3);
        expect_state("R7 recover", SR, SK, SR, SK, 1'b1, 1'b1);
    endtask

    task automatic t_standby;
        en = 1'b0;
        tick(1);
        expect_state("R1 standby", RS, RS, RS, RS, 1'b0, 1'b1);
        en = 1'b1;
        tick(2);
        expect_state("R7 wake wait", SK, SK, SK, SK, 1'b1, 1'b1);
        tick(1);
        expect_state("R7 wake on", SR, SK, SR, SK, 1'b1, 1'b1);
    endtask

    task automatic t_short;
        sc_trip = 4'b0010;
        tick(1);
        sc_trip = 4'b0000;
        expect_state("R9 trip on sinking gate ignored", SR, SK, SR, SK, 1'b1, 1'b1);
        sc_trip = 4'b0001;
        tick(1);
        sc_trip = 4'b0000;
        expect_state("R9 hs_a tripped", SK, SK, SR, SK, 1'b1, 1'b0);
        tick(5);
        expect_state("R10 latch holds", SK, SK, SR, SK, 1'b1, 1'b0);
        dir_in = 1'b1;
        tick(2);
        expect_state("R10 before release", SK, SK, SR, SK, 1'b1, 1'b0);
        tick(1);
        expect_state("R10 released R11", SK, SK, SR, SK, 1'b1, 1'b1);
        tick(2);
        expect_state("R10 dead wait", SK, SK, SR, SK, 1'b1, 1'b1);
        tick(1);
        expect_state("R10 resumed", SR, SK, SR, SK, 1'b1, 1'b1);
    endtask

    task automatic t_zero_dead;
        dead_cycles = 8'd0;
        tick(1);
        pwm_in = 1'b0;
        tick(1);
        expect_state("R7 zero dead latency", SR, SK, SR, SK, 1'b1, 1'b1);
        tick(1);
        expect_state("R7 zero dead immediate", SR, SK, SK, SR, 1'b1, 1'b1);
        dead_cycles = 8'd3;
        tick(1);
    endtask

    initial begin
        t_reset();
        t_forward();
        t_reverse();
        t_brake();
        t_brake_dir_toggle();
        t_faults();
        t_standby();
        t_short();
        t_zero_dead();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule